// File: doc/BRIEF.md
# Protected System Clock Control Unit

This block holds the clock configuration of a small system: two 8-bit control registers, reached over a byte-wide register bus, and a one-bit write-protect register that must be set before either control register accepts a write. From these settings it produces single-cycle tick enables for the CPU, the peripherals and a slow sub-clock-derived peripheral clock. It also drives a clock-output pin selector. The system tick comes either from the sub oscillator or from the main oscillator divided by 1, 2, 4, 8 or 16.

Oscillators arrive as tick inputs (`main_tick`, `sub_tick`) sampled in the block clock domain. All generated clocks are enables, so no derived clock nets exist. A wait input pauses the CPU tick and can optionally pause peripheral ticks. Setting the stop bit halts every tick until `wake` clears it. Entering stop rewrites some configuration bits, depending on whether the system was running from the main or the sub source.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset, control register 0 (bus address 0) reads 0x48, control register 1 (address 1) reads 0x20, and the protect register (address 2) reads 0x00.
- R2: A write to address 0 or 1 takes effect only while protect bit 0 is 1; otherwise the register keeps its value. The protect register is always writable.
- R3: Bits [4:1] of register 1 always read 0. Only bit 0 of the protect register is stored, and its other bits read 0.
- R4: When register 0 bit 6 is 1, the main divide ratio is 8 regardless of register 1 bits [7:6]. Otherwise those bits select the ratio: 00 gives /1, 01 gives /2, 10 gives /4 and 11 gives /16. A change of ratio restarts the divide count.
- R5: Register 0 bit 7 selects the system tick source: 0 selects the divided main oscillator, and 1 selects `sub_tick` directly.
- R6: While `wait_req` is 1, `cpu_tick` is 0. `periph_tick` continues unless register 0 bit 2 is 1. `fc32_tick` (sub tick /32, active while register 0 bit 4 is 1) is unaffected by wait.
- R7: Register 0 bits [1:0] select the clock output. 00 gives port mode (`clkout_port_mode`=1, no `clkout_tick`), 01 gives the sub tick, 10 gives the peripheral tick /8, and 11 gives the peripheral tick /32.
- R8: Writing 1 to register 1 bit 0 enters stop mode. In stop mode all tick outputs are 0 and `main_osc_on` is 0. A `wake` pulse clears the bit on the next edge.
- R9: On stop entry with register 0 bit 7 = 0, register 0 bit 6, register 1 bit 5 and register 0 bit 3 become 1.
- R10: On stop entry with register 0 bit 7 = 1, register 0 bit 6 and register 1 bit 5 keep their previous values, even against the written data. Register 0 bit 3 still becomes 1.
- R11: `main_osc_on` = NOT register 0 bit 5 (outside stop). `sub_pins_on` = register 0 bit 4 (outside stop). `sub_drive_hi` = register 0 bit 3. `main_drive_hi` = register 1 bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0, 1 control, 2 protect) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| main_tick | input | 1 | Main oscillator tick |
| sub_tick | input | 1 | Sub oscillator tick |
| wait_req | input | 1 | Wait-mode request (level) |
| wake | input | 1 | Wake-up from stop mode |
| cpu_tick | output | 1 | CPU clock enable |
| periph_tick | output | 1 | Peripheral clock enable |
| fc32_tick | output | 1 | Sub tick divided by 32 |
| clkout_tick | output | 1 | Clock output pin tick |
| clkout_port_mode | output | 1 | Output pin acts as general port |
| main_osc_on | output | 1 | Main oscillator enable |
| sub_pins_on | output | 1 | Sub oscillator pins enabled |
| main_drive_hi | output | 1 | Main oscillator high drive |
| sub_drive_hi | output | 1 | Sub oscillator high drive |
| stop_mode | output | 1 | Stop mode active |

## Verification
The divider is driven with main ticks on every cycle over windows that are a multiple of every ratio. Each of the four field settings then yields a distinct pulse count, and the /8 override with a /16 field shows the override masking the field. The source select is tried with both oscillators ticking, then with only the main ticking, which separates the sub path from the main path. Stop entry is tried from the main and from the sub source, with written data that differs from the prior bits, so that forcing and retention can be told apart. Writes with protect clear use data that differs from the reset value.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int RW = 8;
  localparam int RATIO_W = 5;
  localparam logic [RATIO_W-1:0] FORCED_RATIO = 5'd8;

  function automatic logic [RATIO_W-1:0] main_ratio(input logic div8, input logic [1:0] sel);
    if (div8) return FORCED_RATIO;
    case (sel)
      2'd0: return 5'd1;
      2'd1: return 5'd2;
      2'd2: return 5'd4;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/sysclk_tickdiv.sv
module sysclk_tickdiv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_out
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick_out = tick_in && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick_in) cnt <= tick_out ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sysclk_maindiv.sv
module sysclk_maindiv
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               pulse
);
  logic [RATIO_W-2:0] cnt;
  logic [RATIO_W-1:0] last;
  logic               same;

  assign same  = (ratio == last);
  assign pulse = tick_in && run && same && (cnt == (RATIO_W-1)'(ratio - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      last <= FORCED_RATIO;
    end else if (!same) begin
      cnt  <= '0;
      last <= ratio;
    end else if (tick_in && run) begin
      cnt <= pulse ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [RW-1:0] bus_wdata,
  input  logic          wake,
  output logic [RW-1:0] bus_rdata,
  output logic [RW-1:0] r0,
  output logic [RW-1:0] r1,
  output logic          prot
);
  logic wr0, wr1, stop_entry;

  assign wr0        = bus_wr && prot && (bus_addr == 2'd0);
  assign wr1        = bus_wr && prot && (bus_addr == 2'd1);
  assign stop_entry = wr1 && bus_wdata[0] && !r1[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0   <= 8'h48;
      r1   <= 8'h20;
      prot <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 2'd2) prot <= bus_wdata[0];
      if (wr0) r0 <= bus_wdata;
      if (wr1) r1 <= {bus_wdata[7:5], 4'b0000, bus_wdata[0]};
      if (stop_entry) begin
        r0[3] <= 1'b1;
        if (!r0[7]) begin
          r0[6] <= 1'b1;
          r1[5] <= 1'b1;
        end else begin
          r1[5] <= r1[5];
        end
      end
      if (wake) r1[0] <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = r0;
      2'd1:    bus_rdata = r1;
      2'd2:    bus_rdata = {7'b0, prot};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
  import sysclk_pkg::*;
#(
  parameter int OUT_DIV_LO = 8,
  parameter int OUT_DIV_HI = 32,
  parameter int SUB_DIV    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [RW-1:0] bus_wdata,
  output logic [RW-1:0] bus_rdata,
  input  logic          main_tick,
  input  logic          sub_tick,
  input  logic          wait_req,
  input  logic          wake,
  output logic          cpu_tick,
  output logic          periph_tick,
  output logic          fc32_tick,
  output logic          clkout_tick,
  output logic          clkout_port_mode,
  output logic          main_osc_on,
  output logic          sub_pins_on,
  output logic          main_drive_hi,
  output logic          sub_drive_hi,
  output logic          stop_mode
);
  logic [RW-1:0] r0_q, r1_q;
  logic          prot_q;
  logic          main_pulse, sys_tick, div_lo, div_hi, sub_gated;
  logic [RATIO_W-1:0] ratio;

  sysclk_regs regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wake(wake), .bus_rdata(bus_rdata),
    .r0(r0_q), .r1(r1_q), .prot(prot_q)
  );

  assign stop_mode     = r1_q[0];
  assign main_osc_on   = !r0_q[5] && !stop_mode;
  assign sub_pins_on   = r0_q[4] && !stop_mode;
  assign sub_drive_hi  = r0_q[3];
  assign main_drive_hi = r1_q[5];
  assign ratio         = main_ratio(r0_q[6], r1_q[7:6]);

  sysclk_maindiv mdiv_i (
    .clk(clk), .rst_n(rst_n), .tick_in(main_tick), .run(main_osc_on),
    .ratio(ratio), .pulse(main_pulse)
  );

  assign sys_tick    = r0_q[7] ? (sub_tick && !stop_mode) : main_pulse;
  assign cpu_tick    = sys_tick && !wait_req;
  assign periph_tick = sys_tick && !(wait_req && r0_q[2]);
  assign sub_gated   = sub_tick && sub_pins_on;

  sysclk_tickdiv #(.DIV(SUB_DIV)) fc32_i (
    .clk(clk), .rst_n(rst_n), .tick_in(sub_gated), .tick_out(fc32_tick)
  );
  sysclk_tickdiv #(.DIV(OUT_DIV_LO)) olo_i (
    .clk(clk), .rst_n(rst_n), .tick_in(periph_tick), .tick_out(div_lo)
  );
  sysclk_tickdiv #(.DIV(OUT_DIV_HI)) ohi_i (
    .clk(clk), .rst_n(rst_n), .tick_in(periph_tick), .tick_out(div_hi)
  );

  assign clkout_port_mode = (r0_q[1:0] == 2'b00);
  always_comb begin
    case (r0_q[1:0])
      2'b01:   clkout_tick = sub_tick && !stop_mode;
      2'b10:   clkout_tick = div_lo;
      2'b11:   clkout_tick = div_hi;
      default: clkout_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/sysclk_ctl_chk.sv
module sysclk_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] r0,
  input logic [7:0] r1,
  input logic       prot,
  input logic       wait_req,
  input logic       cpu_tick,
  input logic       periph_tick,
  input logic       fc32_tick,
  input logic       clkout_tick,
  input logic       clkout_port_mode,
  input logic       main_osc_on,
  input logic       stop_mode
);
  // R2
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !prot) |=> $stable(r0));
  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r1[4:1] == 4'b0000);
  // R6
  wait_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> !cpu_tick);
  // R7
  port_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_port_mode |-> !clkout_tick);
  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (!cpu_tick && !periph_tick && !fc32_tick && !main_osc_on));
  // R9
  stop_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(r1[0]) && !$past(r0[7])) |-> (r0[6] && r1[5] && r0[3]));
  // R10
  stop_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(r1[0]) && $past(r0[7])) |-> (r0[6] == $past(r0[6]) && r1[5] == $past(r1[5]) && r0[3]));
endmodule

bind sysclk_ctl sysclk_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .r0(r0_q), .r1(r1_q), .prot(prot_q), .wait_req(wait_req),
  .cpu_tick(cpu_tick), .periph_tick(periph_tick), .fc32_tick(fc32_tick),
  .clkout_tick(clkout_tick), .clkout_port_mode(clkout_port_mode),
  .main_osc_on(main_osc_on), .stop_mode(stop_mode)
);

// File: tb/sysclk_ctl_tb_top.sv
`timescale 1ns/1ps
module sysclk_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, main_tick = 1'b0, sub_tick = 1'b0, wait_req = 1'b0, wake = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic cpu_tick, periph_tick, fc32_tick, clkout_tick, clkout_port_mode;
  logic main_osc_on, sub_pins_on, main_drive_hi, sub_drive_hi, stop_mode;
  int total = 0, bad = 0;
  int n_cpu, n_per, n_f32, n_out;

  always #2.5 clk = ~clk;

  sysclk_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_tick(main_tick),
    .sub_tick(sub_tick), .wait_req(wait_req), .wake(wake), .cpu_tick(cpu_tick),
    .periph_tick(periph_tick), .fc32_tick(fc32_tick), .clkout_tick(clkout_tick),
    .clkout_port_mode(clkout_port_mode), .main_osc_on(main_osc_on),
    .sub_pins_on(sub_pins_on), .main_drive_hi(main_drive_hi),
    .sub_drive_hi(sub_drive_hi), .stop_mode(stop_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic run(input int cycles, input logic m, input logic s);
    n_cpu = 0; n_per = 0; n_f32 = 0; n_out = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); main_tick = m; sub_tick = s;
      #1;
      n_cpu += int'(cpu_tick); n_per += int'(periph_tick);
      n_f32 += int'(fc32_tick); n_out += int'(clkout_tick);
    end
    @(negedge clk); main_tick = 1'b0; sub_tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1 reg0", d, 8'h48);
    rd(2'd1, d); chk("R1 reg1", d, 8'h20);
    rd(2'd2, d); chk("R1 prot", d, 8'h00);
    chk("R1 stop", stop_mode, 0);
  endtask

  task automatic t_protect;
    logic [7:0] d;
    wr(2'd0, 8'h13); rd(2'd0, d); chk("R2 blocked", d, 8'h48);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R3 prot bits", d, 8'h01);
    wr(2'd0, 8'h18); rd(2'd0, d); chk("R2 allowed", d, 8'h18);
    wr(2'd1, 8'hFE); rd(2'd1, d); chk("R3 reserved", d, 8'hE0);
  endtask

  task automatic t_divider;
    int exp_n[4] = '{64, 32, 16, 4};
    wr(2'd0, 8'h18);
    for (int s = 0; s < 4; s++) begin
      wr(2'd1, {s[1:0], 6'b100000});
      run(64, 1'b1, 1'b0); chk("R4 ratio field", n_cpu, exp_n[s]);
    end
    wr(2'd0, 8'h58);
    run(64, 1'b1, 1'b0); chk("R4 div8 masks /16", n_cpu, 8);
    wr(2'd1, 8'h20);
    run(64, 1'b1, 1'b0); chk("R4 div8 masks /1", n_cpu, 8);
  endtask

  task automatic t_source;
    wr(2'd0, 8'h18); wr(2'd1, 8'hE0);
    run(32, 1'b1, 1'b1); chk("R5 main /16", n_cpu, 2);
    wr(2'd0, 8'h98);
    run(32, 1'b1, 1'b1); chk("R5 sub source", n_cpu, 32);
    run(32, 1'b1, 1'b0); chk("R5 sub ignores main", n_cpu, 0);
  endtask

  task automatic t_wait;
    wr(2'd0, 8'h18); wr(2'd1, 8'h20);
    wait_req = 1'b1;
    run(32, 1'b1, 1'b1);
    chk("R6 cpu held", n_cpu, 0); chk("R6 periph runs", n_per, 32); chk("R6 fc32", n_f32, 1);
    wr(2'd0, 8'h1C);
    run(32, 1'b1, 1'b1);
    chk("R6 periph stopped", n_per, 0); chk("R6 fc32 in wait", n_f32, 1);
    wait_req = 1'b0;
    run(32, 1'b1, 1'b1); chk("R6 cpu resumes", n_cpu, 32);
  endtask

  task automatic t_clkout;
    int exp_o[4] = '{0, 64, 8, 2};
    wr(2'd1, 8'h20);
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, {6'b000110, m[1:0]});
      #1 chk("R7 port flag", clkout_port_mode, (m == 0) ? 1 : 0);
      run(64, 1'b1, 1'b1); chk("R7 clkout count", n_out, exp_o[m]);
    end
  endtask

  task automatic t_pins;
    wr(2'd0, 8'h30);
    #1 chk("R11 main osc off", main_osc_on, 0);
    chk("R11 sub pins", sub_pins_on, 1); chk("R11 sub drive", sub_drive_hi, 0);
    chk("R11 main drive", main_drive_hi, 1);
    wr(2'd0, 8'h08);
    #1 chk("R11 main osc on", main_osc_on, 1); chk("R11 sub pins off", sub_pins_on, 0);
  endtask

  task automatic t_stop_hs;
    logic [7:0] d;
    wr(2'd0, 8'h10); wr(2'd1, 8'h00);
    wr(2'd1, 8'h01);
    rd(2'd0, d); chk("R9 reg0 forced", d, 8'h58);
    rd(2'd1, d); chk("R9 reg1 forced", d, 8'h21);
    chk("R8 stop flag", stop_mode, 1); chk("R8 main osc", main_osc_on, 0);
    run(64, 1'b1, 1'b1);
    chk("R8 cpu", n_cpu, 0); chk("R8 periph", n_per, 0); chk("R8 fc32", n_f32, 0);
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    rd(2'd1, d); chk("R8 wake clears", d, 8'h20);
  endtask

  task automatic t_stop_ls;
    logic [7:0] d;
    wr(2'd0, 8'h90); wr(2'd1, 8'h00);
    wr(2'd1, 8'h21);
    rd(2'd0, d); chk("R10 reg0 kept", d, 8'h98);
    rd(2'd1, d); chk("R10 reg1 kept", d, 8'h01);
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    #1 chk("R8 wake", stop_mode, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_protect();
    t_divider();
    t_source();
    t_wait();
    t_clkout();
    t_pins();
    t_stop_hs();
    t_stop_ls();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule